// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave side of a three-pin configuration port: a serial clock, one bidirectional data line and an active-low select. The host opens a frame by pulling the select low and clocks in a 16-bit command word. The command holds a direction flag, a two-bit length code and a 13-bit register address. One or more 8-bit data bytes follow. A write stores each byte into a small register file. A read turns the data line around so that the block drives the selected register contents back to the host. After every byte the address steps to the next register, so a single frame can cover a run of registers.

The serial pins are oversampled in the system clock domain. The serial clock, select and data pins pass through a two-stage synchronizer, and edge detectors turn the synchronized serial clock into rising and falling events. A framing state machine has five states: `ST_IDLE`, `ST_INSTR`, `ST_DATA`, `ST_STALL` and `ST_DONE`. It steps as follows:

- `ST_IDLE` to `ST_INSTR` when the select falls.
- `ST_INSTR` to `ST_DATA` on the 16th command bit. `ST_INSTR` to `ST_IDLE` if the select rises early (abort).
- `ST_DATA` to `ST_DONE` after the last counted byte.
- `ST_DATA` to `ST_STALL` if the select rises on a byte boundary while counted bytes remain.
- `ST_DATA` to `ST_IDLE` if the select rises mid-byte or during a streaming transfer.
- `ST_STALL` to `ST_DATA` when the select falls again.
- `ST_DONE` to `ST_IDLE` when the select rises.

Bit 0 of register 0 switches the port from most-significant-bit-first to least-significant-bit-first order. The new order takes effect from the next frame.

Top module: `cfg_spi_port`

## Requirements
- R1: After reset the data line is not driven, register k holds (17·k) mod 256, and register 0 holds 0x00, which selects MSB-first order.
- R2: The command word is 16 bits: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the full 13-bit address. All 13 address bits are decoded.
- R3: In a write frame, each 8-bit data byte is stored into the addressed register after its 8th rising serial clock edge.
- R4: In a read frame, the data line is driven from the first falling serial clock edge after the 16th command bit. Each bit is presented on a falling edge, and the host samples it on the next rising edge.
- R5: Length codes 00, 01 and 10 transfer 1, 2 and 3 bytes. Further bits in the same frame are ignored and write nothing.
- R6: Length code 11 streams bytes until the select rises.
- R7: After each byte the address decrements in MSB-first order and increments in LSB-first order, wrapping modulo 2^13.
- R8: Setting bit 0 of register 0 selects LSB-first order for both the command word (address bit 0 first, direction bit last) and the data bytes. Clearing it restores MSB-first. A change applies from the next frame.
- R9: In a counted transfer, raising the select on a byte boundary suspends the frame. The address and the byte count are kept. When the select falls again, the transfer continues with the next byte, and on a read the first bit of that byte is driven at once.
- R10: Raising the select during the command or in the middle of a data byte aborts the frame. The partial byte is not written.
- R11: While the select is high, the data line is not driven.
- R12: Addresses at or above NUM_REGS read as 0x00, and writes to them change no register.
- R13: On a read, the data line is released once the counted bytes are done, for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idles low |
| csn_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Value the block drives onto the data line |
| sdio_oe | output | 1 | Drive enable for the data line pad |

## Verification
The hardest condition to reach is resuming a read after a stall. The select has to rise exactly on a byte boundary of a counted read. Then, when the select falls again, the next byte's first bit must already be on the line before any falling clock edge has occurred. The bench host task has a stall switch that releases and re-asserts the select between every pair of bytes. It uses this in both bit orders, and checks the driven bits after each resume. It also checks that the line is released during each gap.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int CMD_W   = 16;
    localparam int ADDR_W  = CMD_W - 3;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_DATA,
        ST_STALL,
        ST_DONE
    } frame_state_t;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdio_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic csn_s,
    output logic csn_fell,
    output logic sdio_s
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] csn_p;
    logic [STAGES-1:0] dat_p;
    logic              sck_q;
    logic              csn_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p <= '0;
                    csn_p <= '1;
                    dat_p <= '0;
                end else begin
                    sck_p <= sck_i;
                    csn_p <= csn_i;
                    dat_p <= sdio_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p <= '0;
                    csn_p <= '1;
                    dat_p <= '0;
                end else begin
                    sck_p <= {sck_p[STAGES-2:0], sck_i};
                    csn_p <= {csn_p[STAGES-2:0], csn_i};
                    dat_p <= {dat_p[STAGES-2:0], sdio_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck_p[STAGES-1];
            csn_q <= csn_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_q;
    assign sck_fall = ~sck_p[STAGES-1] & sck_q;
    assign csn_s    = csn_p[STAGES-1];
    assign csn_fell = ~csn_p[STAGES-1] & csn_q;
    assign sdio_s   = dat_p[STAGES-1];

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              csn_s,
    input  logic              csn_fell,
    input  logic              sdio_s,
    input  logic              cfg_lsb,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              drive,
    output logic              sdio_bit
);

    localparam logic [3:0] CMD_LAST  = 4'(CMD_W - 1);
    localparam logic [3:0] BYTE_LAST = 4'(BYTE_W - 1);

    frame_state_t      state_q, state_d;
    logic [3:0]        cnt_q;
    logic              lsb_q;
    logic              rd_q;
    logic              stream_q;
    logic [1:0]        rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  sh_q;
    logic [CMD_W-1:0]  sh_next;
    logic              drive_q;
    logic              out_q;

    logic              bit_in;
    logic              cmd_end;
    logic              byte_end;
    logic              last_byte;
    logic              present;
    logic [2:0]        bit_idx;

    assign bit_in    = sck_rise & ~csn_s;
    assign cmd_end   = (state_q == ST_INSTR) && bit_in && (cnt_q == CMD_LAST);
    assign byte_end  = (state_q == ST_DATA) && bit_in && (cnt_q == BYTE_LAST);
    assign last_byte = ~stream_q && (rem_q == 2'd0);
    assign sh_next   = lsb_q ? {sdio_s, sh_q[CMD_W-1:1]} : {sh_q[CMD_W-2:0], sdio_s};
    assign bit_idx   = lsb_q ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);
    assign present   = rd_q && (((state_q == ST_DATA) && sck_fall && ~csn_s) ||
                                ((state_q == ST_STALL) && csn_fell));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (csn_fell) state_d = ST_INSTR;
            ST_INSTR: begin
                if (csn_s)        state_d = ST_IDLE;
                else if (cmd_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (csn_s)
                    state_d = ((cnt_q == 4'd0) && ~stream_q) ? ST_STALL : ST_IDLE;
                else if (byte_end && last_byte)
                    state_d = ST_DONE;
            end
            ST_STALL: if (csn_fell) state_d = ST_DATA;
            ST_DONE:  if (csn_s)    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath: bit count, shifter, address, byte budget
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            lsb_q    <= 1'b0;
            rd_q     <= 1'b0;
            stream_q <= 1'b0;
            rem_q    <= '0;
            addr_q   <= '0;
            sh_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && csn_fell) begin
                lsb_q <= cfg_lsb;
                cnt_q <= '0;
                rd_q  <= 1'b0;
            end else if (state_q == ST_INSTR && bit_in) begin
                sh_q <= sh_next;
                if (cmd_end) begin
                    cnt_q    <= '0;
                    rd_q     <= sh_next[CMD_W-1];
                    rem_q    <= sh_next[CMD_W-2:CMD_W-3];
                    stream_q <= (sh_next[CMD_W-2:CMD_W-3] == 2'b11);
                    addr_q   <= sh_next[ADDR_W-1:0];
                end else begin
                    cnt_q <= cnt_q + 4'd1;
                end
            end else if (state_q == ST_DATA && bit_in) begin
                sh_q <= sh_next;
                if (byte_end) begin
                    cnt_q  <= '0;
                    rem_q  <= rem_q - 2'd1;
                    addr_q <= lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 4'd1;
                end
            end else if (state_q == ST_INSTR && csn_s) begin
                cnt_q <= '0;
            end else if (state_q == ST_DATA && csn_s && cnt_q != 4'd0) begin
                cnt_q <= '0;
            end
        end
    end

    // line driver outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            out_q   <= 1'b0;
        end else if (csn_s || (byte_end && last_byte) ||
                     state_q == ST_IDLE || state_q == ST_INSTR) begin
            drive_q <= 1'b0;
        end else if (present) begin
            drive_q <= 1'b1;
            out_q   <= rd_data[bit_idx];
        end
    end

    assign rd_addr  = addr_q;
    assign wr_en    = byte_end & ~rd_q;
    assign wr_addr  = addr_q;
    assign wr_data  = lsb_q ? sh_next[CMD_W-1:CMD_W-BYTE_W] : sh_next[BYTE_W-1:0];
    assign drive    = drive_q;
    assign sdio_bit = out_q;

    // R11: a deselected frame never keeps the line driven
    a_r11_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> !drive_q);

    // R13: once the counted bytes are done the line is released
    a_r13_done_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !drive_q);

    // R7: every completed byte moves the address by exactly one
    a_r7_address_step: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |=> (addr_q == ($past(lsb_q) ? $past(addr_q) + 1'b1 : $past(addr_q) - 1'b1)));

    // R9: a stalled frame keeps its address and byte budget
    a_r9_stall_holds_context: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && !csn_fell) |=> ($stable(addr_q) && $stable(rem_q)));

endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
    import cfg_spi_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int CFG_ADDR = 0,
    parameter int LSB_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cfg_lsb
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    function automatic logic [BYTE_W-1:0] reset_val(input int k);
        return (k == CFG_ADDR) ? '0 : BYTE_W'(k * 17);
    endfunction

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reset_val(k);
                else if (wr_en && wr_addr == ADDR_W'(k))
                    q <= wr_data;
            end
            assign regs[k] = q;
        end
    endgenerate

    assign rd_data = (rd_addr < ADDR_W'(NUM_REGS)) ? regs[rd_addr[IDX_W-1:0]] : '0;
    assign cfg_lsb = regs[CFG_ADDR][LSB_BIT];

    // R12: a write outside the map leaves every register untouched
    a_r12_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> (regs == $past(regs)));

endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_ADDR    = 0,
    parameter int LSB_BIT     = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe
);

    logic              sck_rise, sck_fall, csn_s, csn_fell, sdio_s;
    logic              cfg_lsb, wr_en, drive, sdio_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;

    cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .csn_i    (csn_i),
        .sdio_i   (sdio_i),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .csn_s    (csn_s),
        .csn_fell (csn_fell),
        .sdio_s   (sdio_s)
    );

    cfg_spi_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .csn_s    (csn_s),
        .csn_fell (csn_fell),
        .sdio_s   (sdio_s),
        .cfg_lsb  (cfg_lsb),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .drive    (drive),
        .sdio_bit (sdio_bit)
    );

    cfg_spi_regs #(
        .NUM_REGS (NUM_REGS),
        .CFG_ADDR (CFG_ADDR),
        .LSB_BIT  (LSB_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_lsb (cfg_lsb)
    );

    // the pad enable drops as soon as the select pin rises
    assign sdio_oe = drive & ~csn_i;
    assign sdio_o  = sdio_bit;

endmodule

// File: tb/cfg_spi_port_bench.sv
module cfg_spi_port_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic csn = 1'b1;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe;

    int checks = 0;
    int fails  = 0;

    logic [7:0] model [0:15];
    bit         lsb_mode = 1'b0;
    logic [7:0] tx_buf [0:31];
    logic [7:0] rx_buf [0:31];
    int         rx_oe  [0:31];

    always #2 clk = ~clk;

    cfg_spi_port u_cfg_spi_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck),
        .csn_i   (csn),
        .sdio_i  (sdio_i),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [12:0] a);
        return (a < 13'd16) ? model[a[3:0]] : 8'h00;
    endfunction

    function automatic int eff_count(input logic [1:0] w, input int n);
        if (w == 2'b11) return n;
        return (n < int'(w) + 1) ? n : int'(w) + 1;
    endfunction

    task automatic send_bit(input logic b);
        sdio_i = b;
        repeat (8) @(negedge clk);
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
    endtask

    // host side of one frame; cut >= 0 raises the select after that many bits
    task automatic xfer(input bit rd, input logic [1:0] w, input logic [12:0] a,
                        input int nbytes, input bit stall, input int cut);
        logic [15:0] iw;
        int sent;
        bit stop;
        iw = {rd, w, a};
        sent = 0;
        stop = 1'b0;
        csn = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (sent == cut) stop = 1'b1;
            if (!stop) begin
                send_bit(lsb_mode ? iw[i] : iw[15-i]);
                sent++;
            end
        end
        for (int b = 0; b < nbytes; b++) begin
            rx_buf[b] = 8'h00;
            rx_oe[b]  = 0;
            if (stall && b > 0 && !stop) begin
                csn = 1'b1;
                repeat (20) @(negedge clk);
                chk("R11 line released in stall gap", int'(sdio_oe), 0);
                csn = 1'b0;
                repeat (6) @(negedge clk);
            end
            for (int j = 0; j < 8; j++) begin
                int pos;
                pos = lsb_mode ? j : 7 - j;
                if (sent == cut) stop = 1'b1;
                if (!stop) begin
                    if (rd) begin
                        sdio_i = 1'b0;
                        repeat (8) @(negedge clk);
                        rx_buf[b][pos] = sdio_o;
                        if (sdio_oe) rx_oe[b]++;
                        sck = 1'b1;
                        repeat (8) @(negedge clk);
                        sck = 1'b0;
                    end else begin
                        send_bit(tx_buf[b][pos]);
                    end
                    sent++;
                end
            end
        end
        repeat (4) @(negedge clk);
        csn = 1'b1;
        repeat (12) @(negedge clk);
        chk("R11 line released after frame", int'(sdio_oe), 0);
    endtask

    task automatic do_write(input logic [1:0] w, input logic [12:0] a,
                            input int n, input bit stall);
        logic [12:0] ad;
        int eff;
        xfer(1'b0, w, a, n, stall, -1);
        eff = eff_count(w, n);
        ad = a;
        for (int i = 0; i < eff; i++) begin
            if (ad < 13'd16) model[ad[3:0]] = tx_buf[i];
            ad = lsb_mode ? ad + 13'd1 : ad - 13'd1;
        end
        lsb_mode = model[0][0];
    endtask

    task automatic do_read(input string req, input logic [1:0] w, input logic [12:0] a,
                           input int n, input bit stall);
        logic [12:0] ad;
        int eff;
        xfer(1'b1, w, a, n, stall, -1);
        eff = eff_count(w, n);
        ad = a;
        for (int i = 0; i < n; i++) begin
            if (i < eff) begin
                chk(req, int'(rx_buf[i]), int'(exp_rd(ad)));
                chk("R4 line driven for each read bit", rx_oe[i], 8);
                ad = lsb_mode ? ad + 13'd1 : ad - 13'd1;
            end else begin
                chk("R13 line released past byte count", rx_oe[i], 0);
            end
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        logic [7:0] v;
        v = 8'(k * 53 + 7);
        if (k == 0) v[0] = 1'b0;
        return v;
    endfunction

    initial begin
        for (int k = 0; k < 16; k++) model[k] = 8'(k * 17);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 line idle after reset", int'(sdio_oe), 0);

        // R1 reset contents read as one stream, R6 streaming length
        do_read("R1", 2'b11, 13'd15, 16, 1'b0);

        // R3 stream write of the whole map, then R6 stream read
        for (int i = 0; i < 16; i++) tx_buf[i] = pat(15 - i);
        do_write(2'b11, 13'd15, 16, 1'b0);
        do_read("R3", 2'b11, 13'd15, 16, 1'b0);
        for (int k = 0; k < 16; k++) do_read("R4", 2'b00, 13'(k), 1, 1'b0);

        // R5 counted lengths with surplus bytes
        do_read("R5", 2'b01, 13'd9, 3, 1'b0);
        tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3; tx_buf[3] = 8'hD4;
        do_write(2'b10, 13'd12, 4, 1'b0);
        do_read("R5", 2'b11, 13'd13, 6, 1'b0);

        // R7 downward wrap through address 0 into the unmapped top
        do_read("R7", 2'b10, 13'd1, 3, 1'b0);

        // R12 unmapped write, R2 full address decode (0x1005 must not alias 5)
        tx_buf[0] = 8'h5A;
        do_write(2'b00, 13'h0100, 1, 1'b0);
        do_read("R12", 2'b00, 13'h0100, 1, 1'b0);
        tx_buf[0] = 8'h77;
        do_write(2'b00, 13'h1005, 1, 1'b0);
        do_read("R2", 2'b00, 13'd5, 1, 1'b0);
        do_read("R12", 2'b11, 13'd15, 16, 1'b0);

        // R9 stalls between bytes, write then read
        tx_buf[0] = 8'h3C; tx_buf[1] = 8'hC3; tx_buf[2] = 8'h96;
        do_write(2'b10, 13'd6, 3, 1'b1);
        do_read("R9", 2'b10, 13'd6, 3, 1'b1);

        // R10 aborts: inside the command and inside the data byte
        tx_buf[0] = 8'hFF;
        xfer(1'b0, 2'b00, 13'd3, 1, 1'b0, 8);
        do_read("R10", 2'b00, 13'd3, 1, 1'b0);
        xfer(1'b0, 2'b00, 13'd3, 1, 1'b0, 20);
        do_read("R10", 2'b00, 13'd3, 1, 1'b0);

        // R8 switch to LSB-first, upward stepping, stall in that order
        tx_buf[0] = 8'h81;
        do_write(2'b00, 13'd0, 1, 1'b0);
        tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56;
        do_write(2'b11, 13'd4, 3, 1'b0);
        do_read("R8", 2'b10, 13'd4, 3, 1'b0);
        do_read("R7", 2'b01, 13'h1FFF, 2, 1'b0);
        do_read("R9", 2'b10, 13'd4, 3, 1'b1);
        tx_buf[0] = 8'h40;
        do_write(2'b00, 13'd0, 1, 1'b0);
        do_read("R8", 2'b00, 13'd4, 1, 1'b0);

        do_read("R6", 2'b11, 13'd15, 16, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule